// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block controls one bank of general-purpose pins (up to 32, set by a parameter). Software reaches it through a simple single-cycle register bus made of an address, a write strobe, write data and combinational read data. Every pin has its own input path: a two-flop synchroniser, then an optional debounce filter. Every pin also has an output latch and an output enable. Each pin can have a pull resistor enabled, and the pull direction is chosen per pin. Output level and output enable are never written directly. Software changes them only through separate set and clear addresses, so several agents can change disjoint pins without a read-modify-write.

Each pin can raise an interrupt on its rising edge, its falling edge, or both. Each edge type has its own enable word and its own pending word. The pending bits are write-one-to-clear, so software acknowledges by writing back the value it read. A single interrupt line is high while any pending bit is set. Debounce is enabled per pin and is clocked by one divider that all pins of the bank share. When debounce is on for a pin, the filtered level is also the one used for edge detection.

The bus has no back-pressure. Every access completes in the cycle its address is presented, and no valid/ready handshake is needed. Reads have no side effects.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Writing a mask to 0x1C sets, and writing to 0x20 clears, the matching output-enable bits. Zero bits leave pins unchanged. The result shows on `pin_oe` one cycle after the write and reads back at 0x10.
- R2: Writing a mask to 0x08 drives the masked pins high, and writing to 0x0C drives them low. Zero bits leave pins unchanged. The result shows on `pin_out` one cycle after the write and reads back at 0x04.
- R3: Reading 0x00 returns each pin's level after two synchroniser flops. With debounce off, a change on `pin_in` becomes readable two clock edges later.
- R4: The rising-edge enable word is at 0x28 and the falling-edge enable word is at 0x2C. A pending bit sets on the edge after an effective-level transition of the matching kind, and only if that pin's matching enable bit was 1 at that time.
- R5: The rising pending word is at 0x30 and the falling pending word is at 0x34. Writing 1 to a bit clears it, and writing 0 leaves it alone. If a new edge arrives in the same cycle as the clear, the bit stays set. A pending bit is never cleared any other way.
- R6: The pull-enable word is at 0x50 and the pull-direction word is at 0x54 (1 = up, 0 = down). `pad_pull_up` is enable AND direction, and `pad_pull_dn` is enable AND NOT direction. The two are never both high on one pin.
- R7: `irq` is the OR of every bit of both pending words. With both enable words at zero and nothing pending, it stays low whatever the pins do.
- R8: The debounce divider sits in bits 29:16 of 0x48. A tick occurs every DIV+1 cycles. Debounce is enabled per pin at 0x24. An enabled pin accepts a new level only once the synchronised value is equal at two consecutive ticks. That filtered level is read at 0x00 and used for edge detection.
- R9: Reset (asynchronous, active low) clears every register. After reset all pins are inputs, pulls are off, debounce is off, nothing is enabled or pending, and `irq` is low.
- R10: The set and clear addresses read as zero. Any unmapped address reads as zero, and writing to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |
| pad_pull_up | output | NPINS | Pull-up request per pin |
| pad_pull_dn | output | NPINS | Pull-down request per pin |
| irq | output | 1 | Combined interrupt, high while anything is pending |

## Verification
The assertions check on every cycle the properties that depend only on local history:
- output level and output enable hold still in any cycle without a write;
- a pending bit never rises unless its enable was set;
- a pending bit never falls unless a clear write happened;
- pull-up and pull-down are exclusive on each pin;
- `irq` is low whenever nothing is pending.

The bench's scenarios are needed to show the rest:
- the exact latency of the synchroniser;
- divider timing and glitch rejection in the debounce filter;
- the set-wins outcome when an edge coincides with a clear;
- the contents of every readback.

Each of these is compared against a behavioural model on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam int DIV_LSB = 16;

  localparam logic [BUS_AW-1:0] OFS_LEVEL    = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_DRV      = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_DRV_SET  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_DRV_CLR  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_DIR      = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_DIR_SET  = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_DIR_CLR  = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_FILT_EN  = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_RISE_EN  = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_FALL_EN  = 8'h2C;
  localparam logic [BUS_AW-1:0] OFS_RISE_PND = 8'h30;
  localparam logic [BUS_AW-1:0] OFS_FALL_PND = 8'h34;
  localparam logic [BUS_AW-1:0] OFS_TICKDIV  = 8'h48;
  localparam logic [BUS_AW-1:0] OFS_PULL_ON  = 8'h50;
  localparam logic [BUS_AW-1:0] OFS_PULL_DIR = 8'h54;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W     = 32,
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [W-1:0]     filt_en,
  input  logic [W-1:0]     lvl_in,
  output logic [W-1:0]     lvl_out
);
  logic [DIV_W-1:0] tick_cnt;
  logic             tick;

  // One free-running divider shared by all pins; >= tolerates a divider
  // lowered below the current count.
  assign tick = (tick_cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic last_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q   <= 1'b0;
        stable_q <= 1'b0;
      end else if (tick) begin
        last_q <= lvl_in[i];
        if (lvl_in[i] == last_q) stable_q <= lvl_in[i];
      end
    end

    assign lvl_out[i] = filt_en[i] ? stable_q : lvl_in[i];
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] rise_ack,
  input  logic [W-1:0] fall_ack,
  output logic [W-1:0] rise_pnd,
  output logic [W-1:0] fall_pnd
);
  logic [W-1:0] lvl_d;
  logic [W-1:0] rise_hit;
  logic [W-1:0] fall_hit;

  assign rise_hit = lvl & ~lvl_d & rise_en;
  assign fall_hit = ~lvl & lvl_d & fall_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d    <= '0;
      rise_pnd <= '0;
      fall_pnd <= '0;
    end else begin
      lvl_d    <= lvl;
      // a fresh edge outranks an acknowledge in the same cycle
      rise_pnd <= (rise_pnd & ~rise_ack) | rise_hit;
      fall_pnd <= (fall_pnd & ~fall_ack) | fall_hit;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DIV_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BUS_DW-1:0] reg_wdata,
  output logic [BUS_DW-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pad_pull_up,
  output logic [NPINS-1:0]  pad_pull_dn,
  output logic              irq
);
  logic [NPINS-1:0] drv_q, dir_q, filt_en_q, rise_en_q, fall_en_q;
  logic [NPINS-1:0] pull_on_q, pull_dir_q;
  logic [DIV_W-1:0] div_q;
  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] sync_lvl, eff_lvl;
  logic [NPINS-1:0] rise_pend, fall_pend;
  logic [NPINS-1:0] rise_ack, fall_ack;

  assign wmask = reg_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q      <= '0;
      dir_q      <= '0;
      filt_en_q  <= '0;
      rise_en_q  <= '0;
      fall_en_q  <= '0;
      pull_on_q  <= '0;
      pull_dir_q <= '0;
      div_q      <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_DRV_SET:  drv_q      <= drv_q | wmask;
        OFS_DRV_CLR:  drv_q      <= drv_q & ~wmask;
        OFS_DIR_SET:  dir_q      <= dir_q | wmask;
        OFS_DIR_CLR:  dir_q      <= dir_q & ~wmask;
        OFS_FILT_EN:  filt_en_q  <= wmask;
        OFS_RISE_EN:  rise_en_q  <= wmask;
        OFS_FALL_EN:  fall_en_q  <= wmask;
        OFS_TICKDIV:  div_q      <= reg_wdata[DIV_LSB +: DIV_W];
        OFS_PULL_ON:  pull_on_q  <= wmask;
        OFS_PULL_DIR: pull_dir_q <= wmask;
        default: ;
      endcase
    end
  end

  assign rise_ack = (reg_wr && reg_addr == OFS_RISE_PND) ? wmask : '0;
  assign fall_ack = (reg_wr && reg_addr == OFS_FALL_PND) ? wmask : '0;

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (sync_lvl)
  );

  gpio_debounce #(.W(NPINS), .DIV_W(DIV_W)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (div_q),
    .filt_en (filt_en_q),
    .lvl_in  (sync_lvl),
    .lvl_out (eff_lvl)
  );

  gpio_edge_irq #(.W(NPINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (eff_lvl),
    .rise_en  (rise_en_q),
    .fall_en  (fall_en_q),
    .rise_ack (rise_ack),
    .fall_ack (fall_ack),
    .rise_pnd (rise_pend),
    .fall_pnd (fall_pend)
  );

  assign pin_out     = drv_q;
  assign pin_oe      = dir_q;
  assign pad_pull_up = pull_on_q & pull_dir_q;
  assign pad_pull_dn = pull_on_q & ~pull_dir_q;
  assign irq         = (|rise_pend) | (|fall_pend);

  function automatic logic [BUS_DW-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_LEVEL:    reg_rdata = widen(eff_lvl);
      OFS_DRV:      reg_rdata = widen(drv_q);
      OFS_DIR:      reg_rdata = widen(dir_q);
      OFS_FILT_EN:  reg_rdata = widen(filt_en_q);
      OFS_RISE_EN:  reg_rdata = widen(rise_en_q);
      OFS_FALL_EN:  reg_rdata = widen(fall_en_q);
      OFS_RISE_PND: reg_rdata = widen(rise_pend);
      OFS_FALL_PND: reg_rdata = widen(fall_pend);
      OFS_TICKDIV:  reg_rdata[DIV_LSB +: DIV_W] = div_q;
      OFS_PULL_ON:  reg_rdata = widen(pull_on_q);
      OFS_PULL_DIR: reg_rdata = widen(pull_dir_q);
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [BUS_AW-1:0] reg_addr,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pad_pull_up,
  input logic [NPINS-1:0]  pad_pull_dn,
  input logic              irq,
  input logic [NPINS-1:0]  rise_pend,
  input logic [NPINS-1:0]  fall_pend,
  input logic [NPINS-1:0]  rise_en,
  input logic [NPINS-1:0]  fall_en
);
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pin_out)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pin_oe)); // R1
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_pend & ~$past(rise_pend) & ~$past(rise_en)) == '0)); // R4
  AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fall_pend & ~$past(fall_pend) & ~$past(fall_en)) == '0)); // R4
  AST_RISE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_RISE_PND) |=> (($past(rise_pend) & ~rise_pend) == '0)); // R5
  AST_FALL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFS_FALL_PND) |=> (($past(fall_pend) & ~fall_pend) == '0)); // R5
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_up & pad_pull_dn) == '0); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pend == '0 && fall_pend == '0) |-> !irq); // R7
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn),
  .irq         (irq),
  .rise_pend   (rise_pend),
  .fall_pend   (fall_pend),
  .rise_en     (rise_en_q),
  .fall_en     (fall_en_q)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int NP = 32;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = 8'h00;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pad_pull_up, pad_pull_dn;
  logic          irq;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  cmp_on = 0;

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NP), .DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .irq(irq)
  );

  // behavioural reference state
  bit [NP-1:0] m_s1, m_s2, m_drv, m_dir, m_fen, m_ren, m_fallen, m_rp, m_fp;
  bit [NP-1:0] m_pon, m_pdir, m_hist, m_filt, m_prev;
  int m_div, m_cnt;

  function automatic bit [NP-1:0] m_eff();
    bit [NP-1:0] e;
    for (int i = 0; i < NP; i++) e[i] = m_fen[i] ? m_filt[i] : m_s2[i];
    return e;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    case (a)
      8'h00: return m_eff();
      8'h04: return m_drv;
      8'h10: return m_dir;
      8'h24: return m_fen;
      8'h28: return m_ren;
      8'h2C: return m_fallen;
      8'h30: return m_rp;
      8'h34: return m_fp;
      8'h48: return m_div << 16;
      8'h50: return m_pon;
      8'h54: return m_pdir;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(bit [7:0] a);
    case (a)
      8'h00: return "R3 R8";
      8'h04, 8'h08, 8'h0C: return "R2";
      8'h10, 8'h1C, 8'h20: return "R1";
      8'h24, 8'h48: return "R8";
      8'h28, 8'h2C: return "R4";
      8'h30, 8'h34: return "R5";
      8'h50, 8'h54: return "R6";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_drv = '0; m_dir = '0; m_fen = '0; m_ren = '0;
      m_fallen = '0; m_rp = '0; m_fp = '0; m_pon = '0; m_pdir = '0;
      m_hist = '0; m_filt = '0; m_prev = '0; m_div = 0; m_cnt = 0;
    end else begin
      bit [NP-1:0] eff, ack_r, ack_f, w;
      bit tick;
      eff = m_eff();
      w = reg_wdata[NP-1:0];
      ack_r = (reg_wr && reg_addr == 8'h30) ? w : '0;
      ack_f = (reg_wr && reg_addr == 8'h34) ? w : '0;
      m_rp = (m_rp & ~ack_r) | (eff & ~m_prev & m_ren);
      m_fp = (m_fp & ~ack_f) | (~eff & m_prev & m_fallen);
      m_prev = eff;
      tick = (m_cnt >= m_div);
      if (tick) begin
        for (int i = 0; i < NP; i++) if (m_s2[i] == m_hist[i]) m_filt[i] = m_s2[i];
        m_hist = m_s2;
        m_cnt = 0;
      end else m_cnt = m_cnt + 1;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (reg_wr) begin
        case (reg_addr)
          8'h08: m_drv = m_drv | w;
          8'h0C: m_drv = m_drv & ~w;
          8'h1C: m_dir = m_dir | w;
          8'h20: m_dir = m_dir & ~w;
          8'h24: m_fen = w;
          8'h28: m_ren = w;
          8'h2C: m_fallen = w;
          8'h48: m_div = int'(reg_wdata[29:16]);
          8'h50: m_pon = w;
          8'h54: m_pdir = w;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !finished) begin
      check("R2", "pin_out", pin_out, m_drv);
      check("R1", "pin_oe", pin_oe, m_dir);
      check("R6", "pad_pull_up", pad_pull_up, m_pon & m_pdir);
      check("R6", "pad_pull_dn", pad_pull_dn, m_pon & ~m_pdir);
      check("R7", "irq", {31'h0, irq}, {31'h0, (|m_rp) | (|m_fp)});
      check(tag(reg_addr), $sformatf("rdata@%h", reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(bit [7:0] a, bit [31:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(bit [7:0] a, int n = 1);
    reg_addr = a;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired before completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1;
    // R9: reset state on outputs and every address
    @(negedge clk);
    check("R9", "pin_oe after reset", pin_oe, '0);
    check("R9", "irq after reset", {31'h0, irq}, 32'h0);
    @(posedge clk); #1;
    for (int a = 0; a < 'h5C; a += 4) rd(8'(a));

    // R1 / R2 set and clear
    wr(8'h1C, 32'h0000_00F0); rd(8'h10);
    wr(8'h20, 32'h0000_0030); rd(8'h10);
    wr(8'h08, 32'hA5A5_0000); rd(8'h04);
    wr(8'h0C, 32'h0505_0000); rd(8'h04);
    wr(8'h08, 32'h0); rd(8'h04);
    rd(8'h08); rd(8'h20);
    // R10 unmapped write has no effect
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40); rd(8'h04); rd(8'h10);

    // R6 pulls
    wr(8'h50, 32'h0000_FF00); wr(8'h54, 32'h0000_3C3C); rd(8'h54); rd(8'h50);

    // R3 sync latency
    pin_in = 32'h1234_5678; rd(8'h00, 4);
    pin_in = 32'h8000_0001; rd(8'h00, 4);

    // R7 no enables: toggles never raise irq
    for (int k = 0; k < 8; k++) begin pin_in = ~pin_in; rd(8'h30, 3); end

    // R4 / R5 edges, acknowledge, collision sweep
    wr(8'h28, 32'h0000_000F); wr(8'h2C, 32'h0000_0010);
    pin_in = 32'h0000_001F; rd(8'h30, 4);
    pin_in = 32'h0000_0000; rd(8'h34, 4);
    wr(8'h30, 32'h0000_0005); rd(8'h30);
    wr(8'h34, 32'h0000_0010); rd(8'h34);
    for (int d = 0; d < 4; d++) begin
      pin_in[0] = ~pin_in[0];
      pin_in[4] = ~pin_in[4];
      rd(8'h30, d);
      wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, 2);
      wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, 2);
    end
    wr(8'h28, 32'h0); wr(8'h2C, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin pin_in = ~pin_in; rd(8'h00, 3); end

    // R8 debounce with divider 3: glitches, then held levels
    wr(8'h48, 32'h0003_0000); rd(8'h48);
    wr(8'h24, 32'h0000_0F00);
    wr(8'h28, 32'h0000_0F00); wr(8'h2C, 32'h0000_0F00);
    pin_in = '0; rd(8'h00, 12);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    pin_in[8] = 1'b1; rd(8'h00); pin_in[8] = 1'b0; rd(8'h00, 10);
    pin_in[9] = 1'b1; rd(8'h00, 3); pin_in[9] = 1'b0; rd(8'h30, 10);
    pin_in[10] = 1'b1; rd(8'h00, 14); rd(8'h30, 2);
    pin_in[10] = 1'b0; rd(8'h00, 14); rd(8'h34, 2);
    // divider 0: a tick every cycle
    wr(8'h48, 32'h0);
    pin_in[11] = 1'b1; rd(8'h00); pin_in[11] = 1'b0; rd(8'h00, 4);
    pin_in[11] = 1'b1; rd(8'h00, 5); rd(8'h30, 2);

    // mixed pseudo-random traffic
    wr(8'h48, 32'h0002_0000);
    wr(8'h28, 32'hF0F0_F0F0); wr(8'h2C, 32'h3333_CCCC);
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 4) pin_in = pin_in ^ lfsr;
      case (lfsr[6:4])
        3'd0: wr(8'h30, lfsr);
        3'd1: wr(8'h34, ~lfsr);
        3'd2: wr(8'h24, lfsr ^ 32'h5A5A_5A5A);
        3'd3: rd(8'h00);
        3'd4: rd(8'h30);
        3'd5: rd(8'h34);
        3'd6: wr(lfsr[8] ? 8'h08 : 8'h0C, lfsr);
        default: rd(8'h00);
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule